// File: doc/BRIEF.md
# PHY Control and Event Endpoint

This block sits between a link-layer controller and a physical-layer transceiver. The link layer sends 8-bit command codes that turn the transmitter on or off and open the bypass path. The block drives the transmit-enable and bypass-control lines directly from those commands. A transmitter that is on can be switched off again, but no command closes the bypass: only reset closes it.

In the other direction, the block reports events to the link layer as 8-bit codes over a valid/ready channel. One event is raised each time an output-off command is accepted. Another is raised when activity first appears on the receive line. Activity detection counts level changes on the receive line inside fixed windows that are aligned to the release of reset.

Events wait in a small queue until the link layer accepts them. When the queue is full, any further event is dropped and a sticky overflow flag is set.

Top module: `phy_ctl_endpoint`

## Requirements
- R1: After reset the transmit enable is low, the bypass is closed (`bypass_open` low), no event is pending, the error and overflow flags are low, the activity flag is low, and `req_ready` is high.
- R2: A request with code 0x00, accepted on a clock edge, drives `tx_enable` low from that edge onward. The request channel is always ready.
- R3: A request with code 0x01 drives `tx_enable` high from the edge on which it is accepted.
- R4: A request with code 0x02 drives `bypass_open` high from the edge on which it is accepted. The bypass then stays open until reset, whatever requests follow, and this request leaves `tx_enable` unchanged.
- R5: Any request code other than 0x00, 0x01 or 0x02 raises `req_err` for exactly one cycle. It leaves `tx_enable` and `bypass_open` unchanged and queues no event.
- R6: Every accepted 0x00 request queues exactly one event with code 0x00, even when the transmitter is already off.
- R7: Receive-line activity is judged over fixed windows of WIN_CYCLES cycles, counted from the first clock edge after reset is released. At the last edge of each window, `link_active` becomes high if MIN_EDGES or more level changes of `rx_line` were seen in that window (8 of 256 by default), and low otherwise.
- R8: Each low-to-high change of `link_active` queues exactly one event with code 0x01. A window that keeps the flag high queues nothing, and neither does a fall of the flag.
- R9: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_code` does not change.
- R10: Events are delivered in the order they arose. An event raised while another is pending is kept in a second slot. When an off event and an activity event arise on the same edge, the off event goes first.
- R11: An event raised while both slots are full, and not freed on that edge, is dropped. `evt_overflow` is then set and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_code | input | 8 | Request code: 0x00 off, 0x01 on, 0x02 open bypass |
| req_ready | output | 1 | Request accepted (always high) |
| req_err | output | 1 | One-cycle pulse for an unknown request code |
| tx_enable | output | 1 | Transmit driver enable |
| bypass_open | output | 1 | Bypass path open |
| rx_line | input | 1 | Receive line level, synchronous to clk |
| link_active | output | 1 | Activity state from the last completed window |
| evt_valid | output | 1 | Event pending |
| evt_ready | input | 1 | Link layer takes the event |
| evt_code | output | 8 | Event code: 0x00 output off, 0x01 network activity |
| evt_overflow | output | 1 | Sticky: an event was lost |

## Verification
The assertions check the following on every cycle:
- the effect of each request on the next cycle;
- that the bypass, once open, stays open;
- that an unknown code leaves the outputs alone;
- that a pending event holds steady under back-pressure;
- that the overflow flag is sticky;
- that the activity flag moves only at a window boundary.

Other properties need the bench's scenarios. These are the threshold of the activity count (7 against 8 changes in one aligned window), the single event per rise of activity, the delivery order of queued events, and the full sweep of every request code outside the three valid ones.

// File: rtl/phy_ctl_pkg.sv
// Package: shared command and event encodings for the PHY control endpoint.
// Assumes 8-bit codes on both the request and the event channel.
package phy_ctl_pkg;
    localparam int CODE_W = 8;

    typedef enum logic [CODE_W-1:0] {
        REQ_TX_OFF      = 8'h00,
        REQ_TX_ON       = 8'h01,
        REQ_BYPASS_OPEN = 8'h02
    } req_code_e;

    typedef enum logic [CODE_W-1:0] {
        EVT_TX_OFF     = 8'h00,
        EVT_NET_ACTIVE = 8'h01
    } evt_code_e;
endpackage

// File: rtl/phy_ctl_req.sv
// Request decoder: turns accepted request codes into the transmit-enable and
// bypass state. It flags unknown codes and emits an off-event push for every
// off request. Assumes every request is accepted on the cycle it is presented.
module phy_ctl_req
    import phy_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    output logic              tx_enable,
    output logic              bypass_open,
    output logic              req_err,
    output logic              off_push
);
    logic is_off, is_on, is_byp, is_bad;

    // Purpose: classify the presented code.
    always_comb begin
        is_off = req_valid && (req_code == REQ_TX_OFF);
        is_on  = req_valid && (req_code == REQ_TX_ON);
        is_byp = req_valid && (req_code == REQ_BYPASS_OPEN);
        is_bad = req_valid && !(is_off || is_on || is_byp);
    end

    assign off_push = is_off;

    // Purpose: hold the transmitter and bypass state and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_enable   <= 1'b0;
            bypass_open <= 1'b0;
            req_err     <= 1'b0;
        end else begin
            req_err <= is_bad;
            if (is_off)      tx_enable <= 1'b0;
            else if (is_on)  tx_enable <= 1'b1;
            if (is_byp)      bypass_open <= 1'b1;
        end
    end

    p_off_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_code == 8'h00) |=> !tx_enable);
    p_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_code == 8'h01) |=> tx_enable);
    p_bypass_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_open |=> bypass_open);
    p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_code > 8'h02) |=> (req_err && $stable(tx_enable) && $stable(bypass_open)));
endmodule

// File: rtl/phy_ctl_activity.sv
// Activity detector: counts level changes of the receive line in fixed windows
// aligned to reset release. It sets the activity flag at a window end when the
// count reached the threshold, and pulses act_rise on a low-to-high change.
// Assumes rx_line is already synchronous to clk and idles low at reset.
module phy_ctl_activity #(
    parameter int WIN_CYCLES = 256,
    parameter int MIN_EDGES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic active,
    output logic act_rise
);
    localparam int WIN_W  = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(MIN_EDGES);

    logic              rx_q;
    logic [WIN_W-1:0]  win_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edges_next;
    logic              toggle, win_end, hit;

    // Purpose: detect a line change and form the saturating count for this cycle.
    always_comb begin
        toggle     = rx_line ^ rx_q;
        edges_next = (edge_cnt == EDGE_MAX) ? edge_cnt : edge_cnt + EDGE_W'(toggle);
        win_end    = (win_cnt == WIN_LAST);
        hit        = (edges_next >= EDGE_MAX);
        act_rise   = win_end && hit && !active;
    end

    // Purpose: advance the window, count changes and judge activity at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            active   <= 1'b0;
        end else begin
            rx_q <= rx_line;
            if (win_end) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                active   <= hit;
            end else begin
                win_cnt  <= win_cnt + WIN_W'(1);
                edge_cnt <= edges_next;
            end
        end
    end

    p_window_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(active));
    p_rise_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_rise |=> active);
endmodule

// File: rtl/phy_ctl_evq.sv
// Event queue: an in-order queue of DEPTH codes with two push ports; port a
// takes precedence over port b. The head entry is offered on a valid/ready
// pair. A push that finds no free slot sets a sticky overflow flag. An entry
// taken on an edge frees its slot on that same edge.
module phy_ctl_evq
    import phy_ctl_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_a,
    input  logic [CODE_W-1:0] code_a,
    input  logic              push_b,
    input  logic [CODE_W-1:0] code_b,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [CODE_W-1:0] evt_code,
    output logic              overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [CODE_W-1:0] slot_q [DEPTH];
    logic [CODE_W-1:0] slot_n [DEPTH];
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              ovf_hit;

    assign evt_valid = (cnt_q != '0);
    assign evt_code  = slot_q[0];

    // Purpose: apply this cycle's pop, then pushes a and b, in that order.
    always_comb begin
        slot_n  = slot_q;
        cnt_n   = cnt_q;
        ovf_hit = 1'b0;
        if (evt_valid && evt_ready) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot_q[i+1];
            cnt_n = cnt_q - CNT_W'(1);
        end
        if (push_a) begin
            if (cnt_n < CNT_FULL) begin
                for (int i = 0; i < DEPTH; i++)
                    if (i == int'(cnt_n)) slot_n[i] = code_a;
                cnt_n = cnt_n + CNT_W'(1);
            end else begin
                ovf_hit = 1'b1;
            end
        end
        if (push_b) begin
            if (cnt_n < CNT_FULL) begin
                for (int i = 0; i < DEPTH; i++)
                    if (i == int'(cnt_n)) slot_n[i] = code_b;
                cnt_n = cnt_n + CNT_W'(1);
            end else begin
                ovf_hit = 1'b1;
            end
        end
    end

    // Purpose: store the queue contents, the fill level and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            cnt_q    <= '0;
            overflow <= 1'b0;
        end else begin
            slot_q <= slot_n;
            cnt_q  <= cnt_n;
            if (ovf_hit) overflow <= 1'b1;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code)));
    p_second_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && cnt_q > CNT_W'(1)) |=> evt_valid);
    p_no_overflow_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/phy_ctl_endpoint.sv
// Top: the PHY control and event endpoint. Requests are decoded into the
// transmitter and bypass controls. Off requests and rises of receive activity
// become queued event reports to the link layer.
// Assumes rx_line is synchronous to clk.
module phy_ctl_endpoint
    import phy_ctl_pkg::*;
#(
    parameter int WIN_CYCLES = 256,
    parameter int MIN_EDGES  = 8,
    parameter int EVT_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    output logic              req_ready,
    output logic              req_err,
    output logic              tx_enable,
    output logic              bypass_open,
    input  logic              rx_line,
    output logic              link_active,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [CODE_W-1:0] evt_code,
    output logic              evt_overflow
);
    logic off_push;
    logic act_rise;

    assign req_ready = 1'b1;

    phy_ctl_req u_req (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .tx_enable(tx_enable), .bypass_open(bypass_open), .req_err(req_err),
        .off_push(off_push)
    );

    phy_ctl_activity #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_act (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .active(link_active), .act_rise(act_rise)
    );

    phy_ctl_evq #(.DEPTH(EVT_DEPTH)) u_evq (
        .clk(clk), .rst_n(rst_n),
        .push_a(off_push), .code_a(EVT_TX_OFF),
        .push_b(act_rise), .code_b(EVT_NET_ACTIVE),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
        .overflow(evt_overflow)
    );

    p_off_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_code == 8'h00 && !evt_valid) |=> (evt_valid && evt_code == 8'h00));
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!tx_enable && !bypass_open && !evt_valid && !evt_overflow));
endmodule

// File: tb/phy_ctl_endpoint_test.sv
module phy_ctl_endpoint_test;
    localparam int WIN = 256;
    localparam int MINE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_code = 8'h00;
    logic       req_ready, req_err, tx_enable, bypass_open;
    logic       rx_line = 1'b0;
    logic       link_active, evt_valid;
    logic       evt_ready = 1'b0;
    logic [7:0] evt_code;
    logic       evt_overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    phy_ctl_endpoint #(.WIN_CYCLES(WIN), .MIN_EDGES(MINE), .EVT_DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_ready(req_ready), .req_err(req_err), .tx_enable(tx_enable),
        .bypass_open(bypass_open), .rx_line(rx_line), .link_active(link_active),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
        .evt_overflow(evt_overflow)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [7:0] code);
        req_valid = 1'b1;
        req_code  = code;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pop_evt(input string tag, input int exp);
        check({tag, " valid"}, int'(evt_valid), 1);
        check({tag, " code"}, int'(evt_code), exp);
        evt_ready = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
    endtask

    task automatic align_window();
        while (cyc % WIN != 0) @(negedge clk);
    endtask

    task automatic toggle_window(input int n);
        align_window();
        for (int k = 0; k < n; k++) begin
            rx_line = ~rx_line;
            @(negedge clk);
            @(negedge clk);
        end
        @(negedge clk);
        align_window();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx", int'(tx_enable), 0);
        check("R1 bypass", int'(bypass_open), 0);
        check("R1 evt", int'(evt_valid), 0);
        check("R1 err", int'(req_err), 0);
        check("R1 ovf", int'(evt_overflow), 0);
        check("R1 active", int'(link_active), 0);
        check("R1 ready", int'(req_ready), 1);

        // R6 off while already off still reports once
        send_req(8'h00);
        check("R6 tx stays off", int'(tx_enable), 0);
        pop_evt("R6 off event", 0);
        check("R6 single event", int'(evt_valid), 0);

        // R3 / R2 on then off
        send_req(8'h01);
        check("R3 tx on", int'(tx_enable), 1);
        check("R3 no event", int'(evt_valid), 0);
        send_req(8'h00);
        check("R2 tx off", int'(tx_enable), 0);
        pop_evt("R2 off event", 0);

        // R5 sweep of unknown codes, with the transmitter off then on
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) send_req(8'h01);
            for (int c = 3; c < 256; c++) begin
                send_req(8'(c));
                check("R5 err pulse", int'(req_err), 1);
                check("R5 tx unchanged", int'(tx_enable), pass);
                check("R5 bypass unchanged", int'(bypass_open), 0);
                check("R5 no event", int'(evt_valid), 0);
            end
            @(negedge clk);
            check("R5 err drops", int'(req_err), 0);
        end

        // R4 bypass opens, tx untouched, stays open
        send_req(8'h02);
        check("R4 bypass open", int'(bypass_open), 1);
        check("R4 tx untouched", int'(tx_enable), 1);
        send_req(8'h00);
        pop_evt("R4 off evt", 0);
        send_req(8'h01);
        check("R4 bypass held", int'(bypass_open), 1);

        // R9 / R10 / R11 queueing and overflow
        send_req(8'h00);
        send_req(8'h00);
        repeat (3) @(negedge clk);
        check("R9 held valid", int'(evt_valid), 1);
        check("R9 held code", int'(evt_code), 0);
        check("R11 no ovf yet", int'(evt_overflow), 0);
        send_req(8'h00);
        check("R11 ovf set", int'(evt_overflow), 1);
        pop_evt("R10 first", 0);
        pop_evt("R10 second", 0);
        check("R11 third dropped", int'(evt_valid), 0);
        check("R11 ovf sticky", int'(evt_overflow), 1);

        // R7 threshold: one change short of the limit
        toggle_window(MINE - 1);
        check("R7 below limit", int'(link_active), 0);
        check("R8 no event below", int'(evt_valid), 0);
        // R7 / R8 exactly at the limit
        toggle_window(MINE);
        check("R7 at limit", int'(link_active), 1);
        check("R8 rise event", int'(evt_valid), 1);
        check("R8 rise code", int'(evt_code), 1);
        // still active for another window: no new event
        toggle_window(MINE);
        check("R7 still active", int'(link_active), 1);
        pop_evt("R8 one event", 1);
        check("R8 no repeat", int'(evt_valid), 0);
        align_window();
        check("R7 falls", int'(link_active), 0);
        check("R8 no fall event", int'(evt_valid), 0);

        // R10 order: off event before a later activity event
        send_req(8'h00);
        toggle_window(MINE + 4);
        check("R10 active", int'(link_active), 1);
        pop_evt("R10 off first", 0);
        pop_evt("R10 act second", 1);
        check("R10 empty", int'(evt_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule